// File: doc/BRIEF.md
# Post-Update Pointer Controller

This block sits beside the register file of a small processor core. It turns the auto-update code of an extended instruction into register increment and decrement commands. These commands are applied after the instruction's own result has been written. Pre-update does not exist.

The instruction supplies:

- an auxiliary flag, which says whether the first operand field holds a register or an immediate;
- a four-bit update code;
- four register addresses: first operand, second operand, destination and predicate register.

The controller also receives the result write address, the predicate outcome and a feature-enable input.

Each update command can target one of four slots. Every slot carries a target register and a signed step of one machine word. Before a slot is issued, the controller:

- redirects any data register to its paired pointer register;
- drops updates that collide with the result write;
- merges duplicate targets.

A code other than no-op is rejected with an exception when the feature is disabled.

Register map at the default parameters:

- Pointer-capable pairs occupy addresses `PAIR_BASE` .. `PAIR_BASE+2*NPAIR-1`, which is 8..15 by default.
- Data registers sit at even offsets: 8, 10, 12 and 14.
- Each pointer sits one address above its data register: 9, 11, 13 and 15.

Top module: `post_update_ctrl`

## Requirements
- R1: Outputs are registered. The commands for an instruction accepted at a rising edge (`issue_i`=1 and `ext_i`=1) appear after that edge. After an edge without such an instruction, and after reset, `upd_vld_o`=0 and `exc_o`=0.
- R2: Slots are numbered 0 (first operand), 1 (second operand), 2 (destination) and 3 (predicate register). With aux=0 the code selects slots as follows:
  - 0: none
  - 1: {0,1,2}
  - 2, 3: {0}
  - 4, 5: {0,1}
  - 6, 7: {1}
  - 8, 9: {0,2}
  - 10, 11: {2}
  - 12, 13: {1,2}
  - 14, 15: {3}
- R3: With aux=1, only code bits [1:0] matter. They select none (0), slot 1 (1), slot 2 (2) or slot 3 (3). Slot 0 is never updated. Bits [3:2] are ignored.
- R4: Every issued slot carries `STEP` as a DELTA_W-bit two's-complement value. The sign is negative for aux=0 codes with bit 0 clear and for aux=1 code 3. It is positive for all other active codes.
- R5: A field naming a data register (even offset inside the pair range) updates the pointer register at the address one above it. Any other field updates the named register itself.
- R6: The destination slot is issued only when the destination field names a data register. Otherwise the destination update is dropped.
- R7: With `res_wr_i`=1, a slot whose target equals `res_addr_i` is dropped. This is the default when `CONFLICT_EXC`=0.
- R8: No two issued slots share a target. On a tie, the lower-numbered slot is kept.
- R9: With `feat_en_i`=0, a non-no-op code raises `exc_o` and issues no slot. A no-op code raises nothing.
- R10: With `pred_i`=0, no slot is issued. The exception of R9 still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| ext_i | input | 1 | The instruction uses the extended form |
| aux_i | input | 1 | First operand field is an immediate |
| code_i | input | 4 | Update code |
| si4_i | input | ADDR_W | First operand register field |
| snd_i | input | ADDR_W | Second operand register field |
| dst_i | input | ADDR_W | Destination register field |
| cnd_i | input | ADDR_W | Predicate register field |
| res_wr_i | input | 1 | The instruction writes a result register |
| res_addr_i | input | ADDR_W | Result register address |
| pred_i | input | 1 | Predicate evaluated true |
| feat_en_i | input | 1 | Post-update feature implemented and enabled |
| upd_vld_o | output | 4 | Per-slot update request |
| upd_addr_o | output | 4*ADDR_W | Per-slot target register, slot s at bits [s*ADDR_W +: ADDR_W] |
| upd_delta_o | output | 4*DELTA_W | Per-slot signed step, slot s at bits [s*DELTA_W +: DELTA_W] |
| exc_o | output | 1 | Unsupported update exception |

## Verification
Directed vectors walk both decode tables. Each vector uses distinct plain registers, so that a wrong slot mask or a wrong sign shows up as a wrong address or delta.

Further vectors each aim at one rule:

- data-register fields, which tell redirection apart from direct updates;
- a destination field naming a plain register or a pointer;
- a target equal to the result address, with the result write flag set and then cleared;
- two fields naming the same pair, which tests merging and its slot order;
- a disabled feature with active codes, no-op codes, and aux=1 codes whose upper bits are set;
- a false predicate.

A long stream of random instructions over the full register range is then compared on every cycle against a behavioural model. This catches interactions between the rules.

// File: rtl/pu_pkg.sv
package pu_pkg;

    localparam int NSLOT  = 4;
    localparam int SL_SI4 = 0;
    localparam int SL_SND = 1;
    localparam int SL_DST = 2;
    localparam int SL_CND = 3;

    // Decoded update request: which slots move and in which direction
    typedef struct packed {
        logic [NSLOT-1:0] sel;
        logic             dec;
    } upd_cmd_t;

    // True when the address is the data half of a pointer pair
    function automatic logic names_data(input int unsigned a,
                                        input int unsigned base,
                                        input int unsigned npair);
        return (a >= base) && (a < base + 2 * npair) && (((a - base) % 2) == 0);
    endfunction

    // True when the address is the pointer half of a pointer pair
    function automatic logic names_pointer(input int unsigned a,
                                           input int unsigned base,
                                           input int unsigned npair);
        return (a >= base) && (a < base + 2 * npair) && (((a - base) % 2) == 1);
    endfunction

endpackage

// File: rtl/pu_decode.sv
module pu_decode
    import pu_pkg::*;
(
    input  logic       aux_i,
    input  logic [3:0] code_i,
    output upd_cmd_t   cmd_o,
    output logic       noop_o
);

    always_comb begin
        cmd_o = '0;
        if (aux_i) begin
            // immediate in first field: that field never moves
            unique case (code_i[1:0])
                2'd0: cmd_o.sel = 4'b0000;
                2'd1: cmd_o.sel = 4'b0010;
                2'd2: cmd_o.sel = 4'b0100;
                default: cmd_o.sel = 4'b1000;
            endcase
            cmd_o.dec = (code_i[1:0] == 2'd3);
            noop_o    = (code_i[1:0] == 2'd0);
        end else begin
            unique case (code_i)
                4'd0:          cmd_o.sel = 4'b0000;
                4'd1:          cmd_o.sel = 4'b0111;
                4'd2, 4'd3:    cmd_o.sel = 4'b0001;
                4'd4, 4'd5:    cmd_o.sel = 4'b0011;
                4'd6, 4'd7:    cmd_o.sel = 4'b0010;
                4'd8, 4'd9:    cmd_o.sel = 4'b0101;
                4'd10, 4'd11:  cmd_o.sel = 4'b0100;
                4'd12, 4'd13:  cmd_o.sel = 4'b0110;
                default:       cmd_o.sel = 4'b1000;
            endcase
            // even columns step down, odd columns step up
            cmd_o.dec = ~code_i[0];
            noop_o    = (code_i == 4'd0);
        end
    end

endmodule

// File: rtl/pu_resolve.sv
module pu_resolve
    import pu_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned PAIR_BASE = 8,
    parameter int unsigned NPAIR     = 4
) (
    input  logic [NSLOT-1:0]        sel_i,
    input  logic [NSLOT*ADDR_W-1:0] fields_i,
    input  logic                    res_wr_i,
    input  logic [ADDR_W-1:0]       res_addr_i,
    output logic [NSLOT-1:0]        keep_o,
    output logic [NSLOT*ADDR_W-1:0] tgt_o,
    output logic                    clash_o
);

    logic [ADDR_W-1:0] tgt   [NSLOT];
    logic [NSLOT-1:0]  elig;
    logic [NSLOT-1:0]  clash;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [ADDR_W-1:0] fld;
        logic              is_data;

        assign fld     = fields_i[s*ADDR_W +: ADDR_W];
        assign is_data = names_data(32'(fld), PAIR_BASE, NPAIR);
        // a data register hands its update to the pointer above it
        assign tgt[s]  = is_data ? fld + ADDR_W'(1) : fld;
        assign tgt_o[s*ADDR_W +: ADDR_W] = tgt[s];

        if (s == SL_DST) begin : g_dst
            assign elig[s] = sel_i[s] & is_data;
        end else begin : g_src
            assign elig[s] = sel_i[s];
        end

        assign clash[s] = elig[s] & res_wr_i & (tgt[s] == res_addr_i);
    end

    // keep the lowest slot per target; result write wins over all
    always_comb begin
        keep_o = '0;
        for (int s = 0; s < NSLOT; s++) begin
            keep_o[s] = elig[s] & ~clash[s];
            for (int p = 0; p < s; p++) begin
                if (keep_o[p] && (tgt[p] == tgt[s])) keep_o[s] = 1'b0;
            end
        end
    end

    assign clash_o = |clash;

endmodule

// File: rtl/post_update_ctrl.sv
module post_update_ctrl
    import pu_pkg::*;
#(
    parameter int unsigned ADDR_W       = 4,
    parameter int unsigned STEP         = 4,
    parameter int unsigned DELTA_W      = 8,
    parameter int unsigned PAIR_BASE    = 8,
    parameter int unsigned NPAIR        = 4,
    parameter bit          CONFLICT_EXC = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      issue_i,
    input  logic                      ext_i,
    input  logic                      aux_i,
    input  logic [3:0]                code_i,
    input  logic [ADDR_W-1:0]         si4_i,
    input  logic [ADDR_W-1:0]         snd_i,
    input  logic [ADDR_W-1:0]         dst_i,
    input  logic [ADDR_W-1:0]         cnd_i,
    input  logic                      res_wr_i,
    input  logic [ADDR_W-1:0]         res_addr_i,
    input  logic                      pred_i,
    input  logic                      feat_en_i,
    output logic [NSLOT-1:0]          upd_vld_o,
    output logic [NSLOT*ADDR_W-1:0]   upd_addr_o,
    output logic [NSLOT*DELTA_W-1:0]  upd_delta_o,
    output logic                      exc_o
);

    localparam int FLD_W = NSLOT * ADDR_W;
    localparam logic [DELTA_W-1:0] D_INC = DELTA_W'(STEP);
    localparam logic [DELTA_W-1:0] D_DEC = DELTA_W'(0) - D_INC;

    upd_cmd_t         cmd;
    logic             noop;
    logic [NSLOT-1:0] keep;
    logic [FLD_W-1:0] tgt;
    logic             clash;
    logic             go;
    logic             apply_ok;
    logic             exc_d;

    pu_decode i_decode (
        .aux_i  (aux_i),
        .code_i (code_i),
        .cmd_o  (cmd),
        .noop_o (noop)
    );

    pu_resolve #(
        .ADDR_W    (ADDR_W),
        .PAIR_BASE (PAIR_BASE),
        .NPAIR     (NPAIR)
    ) i_resolve (
        .sel_i      (cmd.sel),
        .fields_i   ({cnd_i, dst_i, snd_i, si4_i}),
        .res_wr_i   (res_wr_i),
        .res_addr_i (res_addr_i),
        .keep_o     (keep),
        .tgt_o      (tgt),
        .clash_o    (clash)
    );

    assign go       = issue_i & ext_i;
    assign apply_ok = go & feat_en_i & pred_i & ~(CONFLICT_EXC & clash);
    assign exc_d    = go & ((~feat_en_i & ~noop) |
                            (CONFLICT_EXC & feat_en_i & pred_i & clash));

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_vld_o   <= '0;
            upd_addr_o  <= '0;
            upd_delta_o <= '0;
            exc_o       <= 1'b0;
        end else begin
            upd_vld_o   <= apply_ok ? keep : '0;
            upd_addr_o  <= tgt;
            upd_delta_o <= {NSLOT{cmd.dec ? D_DEC : D_INC}};
            exc_o       <= exc_d;
        end
    end

endmodule

// File: rtl/pu_checker.sv
module pu_checker
    import pu_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned STEP      = 4,
    parameter int unsigned DELTA_W   = 8,
    parameter int unsigned PAIR_BASE = 8,
    parameter int unsigned NPAIR     = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     issue_i,
    input logic                     ext_i,
    input logic                     aux_i,
    input logic                     res_wr_i,
    input logic [ADDR_W-1:0]        res_addr_i,
    input logic                     pred_i,
    input logic                     feat_en_i,
    input logic [NSLOT-1:0]         upd_vld_o,
    input logic [NSLOT*ADDR_W-1:0]  upd_addr_o,
    input logic [NSLOT*DELTA_W-1:0] upd_delta_o,
    input logic                     exc_o
);

    localparam logic [DELTA_W-1:0] C_INC = DELTA_W'(STEP);
    localparam logic [DELTA_W-1:0] C_DEC = DELTA_W'(0) - C_INC;

    logic past_ok;
    logic dup;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    always_comb begin
        dup = 1'b0;
        for (int a = 0; a < NSLOT; a++) begin
            for (int b = a + 1; b < NSLOT; b++) begin
                if (upd_vld_o[a] && upd_vld_o[b] &&
                    upd_addr_o[a*ADDR_W +: ADDR_W] == upd_addr_o[b*ADDR_W +: ADDR_W])
                    dup = 1'b1;
            end
        end
    end

    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(issue_i && ext_i) |-> (upd_vld_o == '0) && !exc_o);

    assert_aux_imm_R3: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(issue_i && aux_i) |-> !upd_vld_o[SL_SI4]);

    assert_dst_ptr_R6: assert property (@(posedge clk) disable iff (rst)
        upd_vld_o[SL_DST] |->
            names_pointer(32'(upd_addr_o[SL_DST*ADDR_W +: ADDR_W]), PAIR_BASE, NPAIR));

    assert_unique_R8: assert property (@(posedge clk) disable iff (rst) !dup);

    assert_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(issue_i && ext_i && !feat_en_i) |-> (upd_vld_o == '0));

    assert_pred_R10: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(issue_i && ext_i && !pred_i) |-> (upd_vld_o == '0));

    for (genvar s = 0; s < NSLOT; s++) begin : g_chk
        assert_result_wins_R7: assert property (@(posedge clk) disable iff (rst)
            past_ok && $past(res_wr_i) && upd_vld_o[s] |->
                upd_addr_o[s*ADDR_W +: ADDR_W] != $past(res_addr_i));

        assert_step_R4: assert property (@(posedge clk) disable iff (rst)
            upd_vld_o[s] |->
                (upd_delta_o[s*DELTA_W +: DELTA_W] == C_INC) ||
                (upd_delta_o[s*DELTA_W +: DELTA_W] == C_DEC));
    end

endmodule

bind post_update_ctrl pu_checker #(
    .ADDR_W    (ADDR_W),
    .STEP      (STEP),
    .DELTA_W   (DELTA_W),
    .PAIR_BASE (PAIR_BASE),
    .NPAIR     (NPAIR)
) i_pu_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_i     (issue_i),
    .ext_i       (ext_i),
    .aux_i       (aux_i),
    .res_wr_i    (res_wr_i),
    .res_addr_i  (res_addr_i),
    .pred_i      (pred_i),
    .feat_en_i   (feat_en_i),
    .upd_vld_o   (upd_vld_o),
    .upd_addr_o  (upd_addr_o),
    .upd_delta_o (upd_delta_o),
    .exc_o       (exc_o)
);

// File: tb/test_post_update_ctrl.sv
`timescale 1ns/1ps
module test_post_update_ctrl;

    localparam int AW   = 4;
    localparam int STP  = 4;
    localparam int DW   = 8;
    localparam int PB   = 8;
    localparam int NP   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          b_issue = 0, b_ext = 0, b_aux = 0, b_rw = 0, b_pred = 0, b_feat = 0;
    logic [3:0]    b_code = 0;
    logic [AW-1:0] b_si4 = 0, b_snd = 0, b_dst = 0, b_cnd = 0, b_res = 0;

    logic [3:0]    upd_vld;
    logic [4*AW-1:0] upd_addr;
    logic [4*DW-1:0] upd_delta;
    logic          exc;

    post_update_ctrl i_post_update_ctrl (
        .clk(clk), .rst(rst), .issue_i(b_issue), .ext_i(b_ext), .aux_i(b_aux),
        .code_i(b_code), .si4_i(b_si4), .snd_i(b_snd), .dst_i(b_dst), .cnd_i(b_cnd),
        .res_wr_i(b_rw), .res_addr_i(b_res), .pred_i(b_pred), .feat_en_i(b_feat),
        .upd_vld_o(upd_vld), .upd_addr_o(upd_addr), .upd_delta_o(upd_delta), .exc_o(exc)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [3:0]    exp_vld;
    logic          exp_exc;
    int            exp_addr [4];
    logic [DW-1:0] exp_dlt  [4];

    // Behavioural expectation from the requirements
    function automatic void predict();
        int  mask;
        bit  down;
        bit  is_d;
        int  f [4];
        int  tgt;
        bit  taken;
        exp_vld = 0;
        exp_exc = 0;
        for (int s = 0; s < 4; s++) begin exp_addr[s] = 0; exp_dlt[s] = 0; end
        if (!(b_issue && b_ext)) return;                       // R1
        if (!b_feat) begin                                     // R9
            exp_exc = b_aux ? (b_code[1:0] != 0) : (b_code != 0);
            return;
        end
        if (!b_pred) return;                                   // R10
        if (b_aux) begin                                       // R3
            case (int'(b_code[1:0]))
                1: mask = 2; 2: mask = 4; 3: mask = 8; default: mask = 0;
            endcase
            down = (b_code[1:0] == 3);
        end else begin                                         // R2
            case (int'(b_code))
                0: mask = 0; 1: mask = 7; 2, 3: mask = 1; 4, 5: mask = 3;
                6, 7: mask = 2; 8, 9: mask = 5; 10, 11: mask = 4;
                12, 13: mask = 6; default: mask = 8;
            endcase
            down = !b_code[0];
        end
        f[0] = int'(b_si4); f[1] = int'(b_snd); f[2] = int'(b_dst); f[3] = int'(b_cnd);
        for (int s = 0; s < 4; s++) begin
            if (mask[s] == 0) continue;
            is_d = (f[s] >= PB) && (f[s] < PB + 2*NP) && ((f[s] - PB) % 2 == 0);
            tgt  = is_d ? f[s] + 1 : f[s];                     // R5
            if (s == 2 && !is_d) continue;                     // R6
            if (b_rw && tgt == int'(b_res)) continue;          // R7
            taken = 0;
            for (int p = 0; p < s; p++)
                if (exp_vld[p] && exp_addr[p] == tgt) taken = 1; // R8
            if (taken) continue;
            exp_vld[s]  = 1'b1;
            exp_addr[s] = tgt;
            exp_dlt[s]  = down ? DW'(-STP) : DW'(STP);         // R4
        end
    endfunction

    task automatic compare(input string tag);
        bit bad = 0;
        n_tests++;
        if (upd_vld !== exp_vld || exc !== exp_exc) bad = 1;
        for (int s = 0; s < 4; s++) begin
            if (exp_vld[s] && (int'(upd_addr[s*AW +: AW]) != exp_addr[s] ||
                               upd_delta[s*DW +: DW] !== exp_dlt[s])) bad = 1;
        end
        if (bad) begin
            n_fail++;
            $display("FAIL %s: vld=%b exc=%b addr=%h delta=%h | expected vld=%b exc=%b addr=%0d,%0d,%0d,%0d delta=%h,%h,%h,%h",
                     tag, upd_vld, exc, upd_addr, upd_delta, exp_vld, exp_exc,
                     exp_addr[0], exp_addr[1], exp_addr[2], exp_addr[3],
                     exp_dlt[0], exp_dlt[1], exp_dlt[2], exp_dlt[3]);
        end
    endtask

    // Drive one instruction at a falling edge, compare at the next one
    task automatic apply(input string tag, input logic iss, input logic ext,
                         input logic aux, input logic [3:0] code,
                         input int si4, input int snd, input int dst, input int cnd,
                         input logic rw, input int res, input logic pred, input logic feat);
        b_issue = iss; b_ext = ext; b_aux = aux; b_code = code;
        b_si4 = AW'(si4); b_snd = AW'(snd); b_dst = AW'(dst); b_cnd = AW'(cnd);
        b_rw = rw; b_res = AW'(res); b_pred = pred; b_feat = feat;
        predict();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        predict();
        compare("R1 reset");
        rst = 1'b0;

        // R2 table rows, plain registers
        apply("R2 code1",  1,1,0,4'd1,  2,3,10,0, 1,10, 1,1);
        apply("R2 code4",  1,1,0,4'd4,  1,2,3,4,  0,0,  1,1);
        apply("R2 code9",  1,1,0,4'd9,  5,6,12,7, 0,0,  1,1);
        apply("R2 code13", 1,1,0,4'd13, 1,3,14,5, 0,0,  1,1);
        apply("R2 code14", 1,1,0,4'd14, 1,2,3,6,  0,0,  1,1);
        apply("R2 code15", 1,1,0,4'd15, 1,2,3,6,  0,0,  1,1);
        // R4 direction
        apply("R4 dec",    1,1,0,4'd2,  4,1,2,3,  0,0,  1,1);
        apply("R4 inc",    1,1,0,4'd3,  4,1,2,3,  0,0,  1,1);
        // R3 immediate first field
        apply("R3 snd",    1,1,1,4'd1,  2,5,3,4,  0,0,  1,1);
        apply("R3 hi",     1,1,1,4'b1111, 2,5,3,7, 0,0, 1,1);
        apply("R3 dst",    1,1,1,4'd2,  2,5,12,4, 0,0,  1,1);
        apply("R3 noop",   1,1,1,4'b1100, 2,5,12,4, 0,0, 1,1);
        // R5 redirect
        apply("R5 snd",    1,1,0,4'd7,  1,14,2,3, 0,0,  1,1);
        apply("R5 si4",    1,1,0,4'd2,  8,1,2,3,  0,0,  1,1);
        // R6 destination only through a data register
        apply("R6 plain",  1,1,0,4'd11, 1,2,3,4,  0,0,  1,1);
        apply("R6 ptr",    1,1,0,4'd11, 1,2,9,4,  0,0,  1,1);
        // R7 result wins
        apply("R7 drop",   1,1,0,4'd3,  5,1,2,3,  1,5,  1,1);
        apply("R7 nowr",   1,1,0,4'd3,  5,1,2,3,  0,5,  1,1);
        apply("R7 redir",  1,1,0,4'd6,  1,12,2,3, 1,13, 1,1);
        // R8 merge
        apply("R8 pair",   1,1,0,4'd5,  8,8,2,3,  0,0,  1,1);
        apply("R8 order",  1,1,0,4'd12, 1,10,10,3, 0,0, 1,1);
        // R9 disabled feature
        apply("R9 exc",    1,1,0,4'd3,  1,2,3,4,  0,0,  1,0);
        apply("R9 noop",   1,1,0,4'd0,  1,2,3,4,  0,0,  1,0);
        apply("R9 auxhi",  1,1,1,4'b1100, 1,2,3,4, 0,0, 1,0);
        // R10 predicate false
        apply("R10 off",   1,1,0,4'd15, 1,2,3,4,  0,0,  0,1);
        apply("R10 exc",   1,1,0,4'd1,  1,2,3,4,  0,0,  0,0);
        // R1 no accepted instruction
        apply("R1 idle",   0,1,0,4'd1,  1,2,10,4, 0,0,  1,0);
        apply("R1 short",  1,0,0,4'd1,  1,2,10,4, 0,0,  1,0);

        // Random stream, compared every clock
        for (int k = 0; k < 600; k++) begin
            logic [31:0] r;
            r = $urandom();
            apply(r[4] ? "R3 rnd" : "R2 rnd", (r[0] | r[1]), (r[2] | r[3]), r[4], r[8:5],
                  int'(r[12:9]), int'(r[16:13]), int'(r[20:17]), int'(r[24:21]),
                  r[25], int'(r[29:26]), (r[30] | r[27]), (r[31] | r[26]));
        end

        apply("R1 end", 0,0,0,4'd0, 0,0,0,0, 0,0, 0,0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule